// File: doc/BRIEF.md
# Exponential Special-Case Screening Unit

This block sits in front of a single-precision exponential datapath and inspects the operand before any range reduction starts. It recognises inputs whose exponential is known without calculation: NaN, either infinity, magnitudes so large that the result saturates, and magnitudes so small that the result is one plus the input. When one of these cases holds it raises a bypass flag and presents the direct answer. For the tiny region it also raises a flag telling the downstream adder to form 1.0 + X. In that case the result field carries the constant 1.0.

The threshold tests are built on a general three-bit ordering comparator for single-precision words. The same comparator is also available at the ports as an independent operand pair. All outputs pass through an optional output register, which is enabled by default and is cleared by a synchronous active-high reset.

Top module: `exp_screen`

## Requirements
- R1: An input with exponent field all ones and a non-zero fraction (NaN) raises `bypass` and is returned bit-for-bit on `result`.
- R2: Input 0x7F800000 (+inf) gives result 0x7F800000; input 0xFF800000 (-inf) gives result 0x00000000 (+0); `bypass` is high in both cases.
- R3: A finite input whose magnitude is strictly greater than 89.0 (0x42B20000) gives result 0x7F800000 when the sign is 0 and 0x00000000 when the sign is 1, with `bypass` high and `one_plus_x` low.
- R4: An input whose magnitude is strictly below 2^-25 (0x33000000) raises `bypass` and `one_plus_x`, and `result` is 1.0 (sign 0, biased exponent 127, fraction 0, i.e. 0x3F800000). This includes zeros and denormals.
- R5: An input of exactly ±89.0, exactly ±2^-25, or any magnitude between them raises no bypass. Whenever `bypass` is low, `result` is 0x00000000 and `one_plus_x` is low.
- R6: The checks are applied in priority order NaN, infinity, upper threshold, lower threshold. A NaN of either sign is therefore passed through, even though its magnitude bits exceed 89.0.
- R7: `cmp_code` is a three-bit code with bit 2 set when A > B, bit 1 set when A == B and bit 0 set when B > A. Exactly one bit is set for every operand pair.
- R8: The comparator orders operands by sign first, with a positive word greater than a negative one. Within the same sign it compares the exponent and fraction bits as an unsigned magnitude, and the order is reversed for negatives. +0 and -0 compare equal.
- R9: With the output register enabled (the default), every output changes one clock edge after its inputs. A reset edge clears `bypass`, `one_plus_x`, `result` and `cmp_code` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| x_in | input | 32 | Single-precision operand to screen |
| cmp_a | input | 32 | Comparator operand A |
| cmp_b | input | 32 | Comparator operand B |
| bypass | output | 1 | Result is produced directly; the exponential datapath is not needed |
| one_plus_x | output | 1 | Tiny-input region: the final result is 1.0 + X |
| result | output | 32 | Direct result while bypass is high, zero otherwise |
| cmp_code | output | 3 | Ordering code of A against B: {A>B, A==B, B>A} |

## Verification
The screening path and the stand-alone comparator share one output register, so a screening outcome and a comparator decision land together in the same cycle. Every table vector drives a screening operand and a comparator pair at the same time. The pairs are chosen so that they are unrelated to the screened value, for example a NaN screened while +0 is compared with -0. The bench then judges both outputs at the same sampling point against expected values written from the requirements. A mix-up between the shared comparator logic and the two threshold instances would therefore show up as a wrong value on one of the two functions.

// File: rtl/exp_screen_pkg.sv
package exp_screen_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int MAG_W  = WORD_W - 1;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

    localparam int NUM_THR       = 2;
    localparam int THR_UPPER_IDX = 0;
    localparam int THR_LOWER_IDX = 1;

    // 89.0 = 1.390625 * 2^6 ; 2^-25 = 1.0 * 2^-25
    localparam int UPPER_EXP_UNB = 6;
    localparam logic [FRAC_W-1:0] UPPER_FRAC = FRAC_W'(23'h320000);
    localparam int LOWER_EXP_UNB = -25;

    typedef enum logic [2:0] {
        SCR_NAN,
        SCR_POS_INF,
        SCR_NEG_INF,
        SCR_OVER,
        SCR_UNDER,
        SCR_TINY,
        SCR_NONE
    } scr_class_e;

    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } cmp_code_t;

    typedef struct packed {
        logic              bypass;
        logic              one_plus_x;
        logic [WORD_W-1:0] result;
    } scr_out_t;

    typedef struct packed {
        scr_out_t  scr;
        cmp_code_t cmp;
    } stage_t;

    localparam int STAGE_W = $bits(stage_t);

    function automatic logic [WORD_W-1:0] fp_pack(input logic s, input int unb_exp,
                                                  input logic [FRAC_W-1:0] f);
        logic [EXP_W-1:0] e;
        e = EXP_W'(unb_exp + BIAS);
        return {s, e, f};
    endfunction

    function automatic logic [WORD_W-1:0] fp_one();
        return fp_pack(1'b0, 0, '0);
    endfunction

    function automatic logic [WORD_W-1:0] fp_pos_inf();
        return {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    endfunction

    function automatic logic [WORD_W-1:0] fp_pos_zero();
        return '0;
    endfunction

    function automatic logic [WORD_W-1:0] thr_value(input int idx);
        if (idx == THR_UPPER_IDX)
            return fp_pack(1'b0, UPPER_EXP_UNB, UPPER_FRAC);
        else
            return fp_pack(1'b0, LOWER_EXP_UNB, '0);
    endfunction

endpackage

// File: rtl/fp_cmp3.sv
module fp_cmp3
    import exp_screen_pkg::*;
(
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output cmp_code_t         code
);

    logic             sign_a;
    logic             sign_b;
    logic [MAG_W-1:0] mag_a;
    logic [MAG_W-1:0] mag_b;
    logic             both_zero;
    logic             mag_gt;
    logic             mag_eq;

    assign sign_a    = a[WORD_W-1];
    assign sign_b    = b[WORD_W-1];
    assign mag_a     = a[MAG_W-1:0];
    assign mag_b     = b[MAG_W-1:0];
    assign both_zero = (mag_a == '0) && (mag_b == '0);
    assign mag_gt    = mag_a > mag_b;
    assign mag_eq    = mag_a == mag_b;

    always_comb begin
        code = '0;
        if (both_zero || ((sign_a == sign_b) && mag_eq)) begin
            code.eq = 1'b1;
        end else if (sign_a != sign_b) begin
            if (!sign_a) code.gt = 1'b1;
            else         code.lt = 1'b1;
        end else if (!sign_a) begin
            if (mag_gt) code.gt = 1'b1;
            else        code.lt = 1'b1;
        end else begin
            if (mag_gt) code.lt = 1'b1;
            else        code.gt = 1'b1;
        end
    end

endmodule

// File: rtl/exp_screen_classify.sv
module exp_screen_classify
    import exp_screen_pkg::*;
(
    input  logic [WORD_W-1:0] x,
    output scr_class_e        cls
);

    logic [EXP_W-1:0]  exp_field;
    logic [FRAC_W-1:0] frac_field;
    logic              sign_bit;
    logic              exp_max;
    logic              frac_nz;
    logic [WORD_W-1:0] abs_word;
    cmp_code_t         thr_code [NUM_THR];

    assign sign_bit   = x[WORD_W-1];
    assign exp_field  = x[WORD_W-2 -: EXP_W];
    assign frac_field = x[FRAC_W-1:0];
    assign exp_max    = &exp_field;
    assign frac_nz    = |frac_field;
    assign abs_word   = {1'b0, x[MAG_W-1:0]};

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        fp_cmp3 u_thr_cmp (
            .a    (abs_word),
            .b    (thr_value(t)),
            .code (thr_code[t])
        );
    end

    always_comb begin
        if (exp_max && frac_nz)
            cls = SCR_NAN;
        else if (exp_max)
            cls = sign_bit ? SCR_NEG_INF : SCR_POS_INF;
        else if (thr_code[THR_UPPER_IDX].gt)
            cls = sign_bit ? SCR_UNDER : SCR_OVER;
        else if (thr_code[THR_LOWER_IDX].lt)
            cls = SCR_TINY;
        else
            cls = SCR_NONE;
    end

endmodule

// File: rtl/exp_screen_result.sv
module exp_screen_result
    import exp_screen_pkg::*;
(
    input  logic [WORD_W-1:0] x,
    input  scr_class_e        cls,
    output scr_out_t          out
);

    always_comb begin
        out = '0;
        unique case (cls)
            SCR_NAN: begin
                out.bypass = 1'b1;
                out.result = x;
            end
            SCR_POS_INF, SCR_OVER: begin
                out.bypass = 1'b1;
                out.result = fp_pos_inf();
            end
            SCR_NEG_INF, SCR_UNDER: begin
                out.bypass = 1'b1;
                out.result = fp_pos_zero();
            end
            SCR_TINY: begin
                out.bypass     = 1'b1;
                out.one_plus_x = 1'b1;
                out.result     = fp_one();
            end
            default: out = '0;
        endcase
    end

endmodule

// File: rtl/exp_screen_outreg.sv
module exp_screen_outreg #(
    parameter bit REG_OUT = 1'b1,
    parameter int WIDTH   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= d;
        end
    end else begin : g_wire
        logic unused_ctl;
        assign unused_ctl = clk ^ rst;
        assign q = d;
    end

endmodule

// File: rtl/exp_screen.sv
module exp_screen
    import exp_screen_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] x_in,
    input  logic [WORD_W-1:0] cmp_a,
    input  logic [WORD_W-1:0] cmp_b,
    output logic              bypass,
    output logic              one_plus_x,
    output logic [WORD_W-1:0] result,
    output logic [2:0]        cmp_code
);

    scr_class_e cls;
    scr_out_t   scr_d;
    cmp_code_t  cmp_d;
    stage_t     stage_d;
    stage_t     stage_q;

    exp_screen_classify u_classify (
        .x   (x_in),
        .cls (cls)
    );

    exp_screen_result u_result (
        .x   (x_in),
        .cls (cls),
        .out (scr_d)
    );

    fp_cmp3 u_user_cmp (
        .a    (cmp_a),
        .b    (cmp_b),
        .code (cmp_d)
    );

    assign stage_d.scr = scr_d;
    assign stage_d.cmp = cmp_d;

    exp_screen_outreg #(
        .REG_OUT (REG_OUT),
        .WIDTH   (STAGE_W)
    ) u_outreg (
        .clk (clk),
        .rst (rst),
        .d   (stage_d),
        .q   (stage_q)
    );

    assign bypass     = stage_q.scr.bypass;
    assign one_plus_x = stage_q.scr.one_plus_x;
    assign result     = stage_q.scr.result;
    assign cmp_code   = stage_q.cmp;

endmodule

// File: rtl/exp_screen_chk.sv
module exp_screen_chk #(
    parameter bit REG_OUT = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic [31:0] x_in,
    input logic [31:0] cmp_a,
    input logic [31:0] cmp_b,
    input logic        bypass,
    input logic        one_plus_x,
    input logic [31:0] result,
    input logic [2:0]  cmp_code
);

    logic        primed;
    logic [31:0] x_q;
    logic [31:0] a_q;
    logic [31:0] b_q;
    logic [31:0] x_v;
    logic [31:0] a_v;
    logic [31:0] b_v;

    always_ff @(posedge clk) begin
        if (rst) primed <= 1'b0;
        else     primed <= 1'b1;
        x_q <= x_in;
        a_q <= cmp_a;
        b_q <= cmp_b;
    end

    assign x_v = REG_OUT ? x_q : x_in;
    assign a_v = REG_OUT ? a_q : cmp_a;
    assign b_v = REG_OUT ? b_q : cmp_b;

    // R1 / R6: NaN of either sign is passed through untouched
    a_r1_nan_passthru: assert property (@(posedge clk) disable iff (rst)
        (primed && (x_v[30:23] == 8'hFF) && (x_v[22:0] != 23'd0))
        |-> (bypass && (result == x_v)));

    // R2: negative infinity becomes +0
    a_r2_neg_inf_zero: assert property (@(posedge clk) disable iff (rst)
        (primed && (x_v == 32'hFF800000)) |-> (bypass && (result == 32'h0)));

    // R3: finite positive above 89.0 saturates to +inf
    a_r3_overflow_inf: assert property (@(posedge clk) disable iff (rst)
        (primed && !x_v[31] && (x_v[30:23] != 8'hFF) && (x_v[30:0] > 31'h42B20000))
        |-> (bypass && !one_plus_x && (result == 32'h7F800000)));

    // R4: tiny flag always comes with bypass and a 1.0 result
    a_r4_tiny_one: assert property (@(posedge clk) disable iff (rst)
        (primed && one_plus_x) |-> (bypass && (result == 32'h3F800000)));

    // R5: no bypass means a clean result field
    a_r5_no_bypass_clean: assert property (@(posedge clk) disable iff (rst)
        (primed && !bypass) |-> ((result == 32'h0) && !one_plus_x));

    // R7: comparator code is one-hot
    a_r7_cmp_onehot: assert property (@(posedge clk) disable iff (rst)
        primed |-> ($countones(cmp_code) == 1));

    // R8: zeros of any sign compare equal
    a_r8_zero_equal: assert property (@(posedge clk) disable iff (rst)
        (primed && (a_v[30:0] == 31'd0) && (b_v[30:0] == 31'd0))
        |-> (cmp_code == 3'b010));

endmodule

bind exp_screen exp_screen_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .x_in       (x_in),
    .cmp_a      (cmp_a),
    .cmp_b      (cmp_b),
    .bypass     (bypass),
    .one_plus_x (one_plus_x),
    .result     (result),
    .cmp_code   (cmp_code)
);

// File: tb/exp_screen_test.sv
`timescale 1ns/1ps
module exp_screen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] x_in  = 32'h0;
    logic [31:0] cmp_a = 32'h0;
    logic [31:0] cmp_b = 32'h0;
    logic        bypass;
    logic        one_plus_x;
    logic [31:0] result;
    logic [2:0]  cmp_code;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    exp_screen uut (
        .clk        (clk),
        .rst        (rst),
        .x_in       (x_in),
        .cmp_a      (cmp_a),
        .cmp_b      (cmp_b),
        .bypass     (bypass),
        .one_plus_x (one_plus_x),
        .result     (result),
        .cmp_code   (cmp_code)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [31:0] x;
        logic [31:0] a;
        logic [31:0] b;
        logic        byp;
        logic        opx;
        logic [31:0] res;
        logic [2:0]  cmp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        // R1: quiet NaN passthrough; 1.0 vs 2.0 -> B greater
        '{4'd1, 32'h7FC00000, 32'h3F800000, 32'h40000000, 1'b1, 1'b0, 32'h7FC00000, 3'b001},
        // R6: negative NaN, magnitude bits above 89; 2.0 vs 1.0 -> A greater
        '{4'd6, 32'hFFC00001, 32'h40000000, 32'h3F800000, 1'b1, 1'b0, 32'hFFC00001, 3'b100},
        // R2: +inf; +0 vs -0 equal (R8)
        '{4'd2, 32'h7F800000, 32'h00000000, 32'h80000000, 1'b1, 1'b0, 32'h7F800000, 3'b010},
        // R2: -inf -> +0; -0 vs +0 equal (R8)
        '{4'd2, 32'hFF800000, 32'h80000000, 32'h00000000, 1'b1, 1'b0, 32'h00000000, 3'b010},
        // R3: just above +89; -1 vs +1
        '{4'd3, 32'h42B20001, 32'hBF800000, 32'h3F800000, 1'b1, 1'b0, 32'h7F800000, 3'b001},
        // R3: just below -89; -2 vs -1
        '{4'd3, 32'hC2B20001, 32'hC0000000, 32'hBF800000, 1'b1, 1'b0, 32'h00000000, 3'b001},
        // R5: exactly +89; equal operands
        '{4'd5, 32'h42B20000, 32'h42B20000, 32'h42B20000, 1'b0, 1'b0, 32'h00000000, 3'b010},
        // R5: exactly -89; +1 vs -1
        '{4'd5, 32'hC2B20000, 32'h3F800000, 32'hBF800000, 1'b0, 1'b0, 32'h00000000, 3'b100},
        // R4: just below 2^-25; +inf vs 89
        '{4'd4, 32'h32FFFFFF, 32'h7F800000, 32'h42B20000, 1'b1, 1'b1, 32'h3F800000, 3'b100},
        // R4: +0; -1 vs -2 -> A greater (R8)
        '{4'd4, 32'h00000000, 32'hBF800000, 32'hC0000000, 1'b1, 1'b1, 32'h3F800000, 3'b100},
        // R4: negative denormal; smallest +denormal vs smallest -denormal
        '{4'd4, 32'h80000001, 32'h00000001, 32'h80000001, 1'b1, 1'b1, 32'h3F800000, 3'b100},
        // R5: exactly 2^-25; one ulp apart
        '{4'd5, 32'h33000000, 32'h33000000, 32'h33000001, 1'b0, 1'b0, 32'h00000000, 3'b001},
        // R5: 1.0; -2^-25 vs +2^-25
        '{4'd5, 32'h3F800000, 32'hB3000000, 32'h33000000, 1'b0, 1'b0, 32'h00000000, 3'b001},
        // R3: largest finite; smallest normal vs largest denormal
        '{4'd3, 32'h7F7FFFFF, 32'h00800000, 32'h007FFFFF, 1'b1, 1'b0, 32'h7F800000, 3'b100},
        // R5: -88.99..; -inf vs most negative finite
        '{4'd5, 32'hC2B1FFFF, 32'hFF800000, 32'hFF7FFFFF, 1'b0, 1'b0, 32'h00000000, 3'b001}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        total++;
        fails++;
        $display("FAIL watchdog: run hung actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R9: reset clears all outputs even with live inputs
        x_in  = 32'h7FC00000;
        cmp_a = 32'h40000000;
        cmp_b = 32'h3F800000;
        repeat (3) @(negedge clk);
        chk("R9 reset bypass", {31'd0, bypass}, 32'd0);
        chk("R9 reset one_plus_x", {31'd0, one_plus_x}, 32'd0);
        chk("R9 reset result", result, 32'd0);
        chk("R9 reset cmp_code", {29'd0, cmp_code}, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            x_in  = VEC[i].x;
            cmp_a = VEC[i].a;
            cmp_b = VEC[i].b;
            @(negedge clk);
            chk($sformatf("R%0d vec%0d bypass", VEC[i].req, i), {31'd0, bypass}, {31'd0, VEC[i].byp});
            chk($sformatf("R%0d vec%0d one_plus_x", VEC[i].req, i), {31'd0, one_plus_x}, {31'd0, VEC[i].opx});
            chk($sformatf("R%0d vec%0d result", VEC[i].req, i), result, VEC[i].res);
            chk($sformatf("R7/R8 vec%0d cmp_code", i), {29'd0, cmp_code}, {29'd0, VEC[i].cmp});
        end

        // R9: new input is not visible before the next edge
        x_in  = 32'h7F800000;
        cmp_a = 32'h3F800000;
        cmp_b = 32'h3F800000;
        #1;
        chk("R9 latency bypass held", {31'd0, bypass}, 32'd0);
        chk("R9 latency cmp held", {29'd0, cmp_code}, 32'd1);
        @(negedge clk);
        chk("R9 latency result updated", result, 32'h7F800000);
        chk("R9 latency cmp updated", {29'd0, cmp_code}, 32'd2);

        // R9: reset in mid-run clears outputs again
        rst = 1'b1;
        @(negedge clk);
        chk("R9 midrun reset bypass", {31'd0, bypass}, 32'd0);
        chk("R9 midrun reset result", result, 32'd0);
        chk("R9 midrun reset cmp_code", {29'd0, cmp_code}, 32'd0);
        rst = 1'b0;

        finish_run();
    end

endmodule